// File: doc/BRIEF.md
# Packed Integer Add/Subtract Unit

A purely combinational 64-bit packed-integer adder and subtractor. The word is split into independent lanes of 8, 16 or 32 bits. Each lane adds the source operand to the destination operand, or subtracts the source from the destination. The result is meant to be written back in place of the destination. Carries and borrows never cross a lane boundary.

Three overflow policies share one datapath:
- **Wraparound** keeps the low bits of each lane.
- **Signed saturation** clamps each lane to its two's-complement range.
- **Unsigned saturation** clamps each lane to 0..2^n-1.

Saturation exists only for 8-bit and 16-bit lanes. A request for saturation on 32-bit lanes, or a request that uses a reserved encoding, raises an illegal-operation output. The unit has no condition flags.

Top module: `packed_addsub64`

## Requirements
- R1: With `mode_i`=0 (wraparound), each lane result is (dst + src) or (dst - src) modulo 2^n. Lane width is set by `size_i`: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits.
- R2: With `mode_i`=1 (signed saturation) and 8-bit or 16-bit lanes, each lane result is the exact signed result, clamped to -2^(n-1)..2^(n-1)-1.
- R3: With `mode_i`=2 (unsigned saturation), an add that exceeds 2^n-1 yields all ones in that lane. Otherwise the lane holds the exact sum.
- R4: With `mode_i`=2, a subtract whose result would be negative yields 0 in that lane. Otherwise the lane holds the exact difference.
- R5: With `sub_i`=1, every lane computes destination minus source. With `sub_i`=0, every lane computes destination plus source.
- R6: A carry or borrow out of one lane never changes any other lane.
- R7: `illegal_o` is 1 whenever `mode_i` is 1 or 2 while `size_i` is 2. It is 0 for every legal combination.
- R8: `size_i`=3 or `mode_i`=3 also sets `illegal_o`. Whenever `illegal_o` is 1, `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 64 | Destination operand (first operand, minuend) |
| src_i | input | 64 | Source operand (second operand, subtrahend) |
| sub_i | input | 1 | 0 = add, 1 = subtract (dst - src) |
| size_i | input | 2 | Lane width: 0 = 8, 1 = 16, 2 = 32, 3 = reserved |
| mode_i | input | 2 | 0 = wrap, 1 = signed sat, 2 = unsigned sat, 3 = reserved |
| res_o | output | 64 | Packed result |
| illegal_o | output | 1 | Unsupported size/mode combination |

## Verification
The unit holds no state, so any internal fault shows at `res_o` in the same evaluation as the inputs that expose it.

Each failure has its own pattern at the ports:
- A broken carry cut corrupts the byte just above a lane boundary, and only for operands that carry or borrow across it.
- A wrong overflow detector shows up only near the signed and unsigned limits.

The sweep therefore combines boundary values with random words, for every size, mode and direction.

// File: rtl/packed_addsub64.sv
module packed_addsub64 (
  input  logic [63:0] dst_i,
  input  logic [63:0] src_i,
  input  logic        sub_i,
  input  logic [1:0]  size_i,
  input  logic [1:0]  mode_i,
  output logic [63:0] res_o,
  output logic        illegal_o
);
  localparam int NB = 8;

  logic [2:0]    grp;
  logic [NB-1:0] cout, sov, uov;
  logic [7:0]    sum [NB];

  assign grp = (size_i == 2'd0) ? 3'd0 : (size_i == 2'd1) ? 3'd1 : 3'd3;
  assign illegal_o = (size_i == 2'd3) || (mode_i == 2'd3) ||
                     ((mode_i != 2'd0) && (size_i == 2'd2));

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [2:0] KK = 3'(k);
    logic [7:0] a, b, sat;
    logic       cin, top, neg;
    logic [2:0] t;

    assign a = dst_i[8*k +: 8];
    assign b = src_i[8*k +: 8] ^ {8{sub_i}};
    if (k == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_rest
      assign cin = ((KK & grp) == 3'd0) ? sub_i : cout[k-1];
    end
    assign {cout[k], sum[k]} = {1'b0, a} + {1'b0, b} + {8'd0, cin};
    assign sov[k] = (a[7] == b[7]) && (sum[k][7] != a[7]);
    assign uov[k] = cout[k] ^ sub_i;

    assign t   = KK | grp;
    assign top = (t == KK);
    assign neg = dst_i[{t, 3'b111}];

    always_comb begin
      sat = sum[k];
      if (mode_i == 2'd1 && sov[t])
        sat = top ? (neg ? 8'h80 : 8'h7F) : (neg ? 8'h00 : 8'hFF);
      else if (mode_i == 2'd2 && uov[t])
        sat = sub_i ? 8'h00 : 8'hFF;
    end

    assign res_o[8*k +: 8] = illegal_o ? 8'h00 : sat;
  end
endmodule

module packed_addsub64_chk (
  input logic [63:0] dst_i,
  input logic [63:0] src_i,
  input logic        sub_i,
  input logic [1:0]  size_i,
  input logic [1:0]  mode_i,
  input logic [63:0] res_o,
  input logic        illegal_o
);
  always_comb begin
    a_r7_sat_dword_illegal: assert (!((mode_i == 2'd1 || mode_i == 2'd2) && size_i == 2'd2) || illegal_o);
    a_r8_illegal_zero: assert (!illegal_o || res_o == 64'd0);
    for (int k = 0; k < 8; k++) begin
      if (!illegal_o && mode_i == 2'd2 && size_i == 2'd0 && sub_i)
        a_r4_usub_below: assert (res_o[8*k +: 8] <= dst_i[8*k +: 8]);
      if (!illegal_o && mode_i == 2'd2 && size_i == 2'd0 && !sub_i)
        a_r3_uadd_above: assert (res_o[8*k +: 8] >= dst_i[8*k +: 8]);
    end
    if (mode_i == 2'd0 && size_i != 2'd3 && src_i == 64'd0)
      a_r1_identity: assert (res_o == dst_i);
  end
endmodule

bind packed_addsub64 packed_addsub64_chk u_chk (.*);

// File: tb/packed_addsub64_tb.sv
module packed_addsub64_tb;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [63:0] dst, src, res;
  logic        sub, illegal;
  logic [1:0]  size, mode;
  int checks = 0, failures = 0;
  bit done = 0;

  packed_addsub64 u_dut (.dst_i(dst), .src_i(src), .sub_i(sub), .size_i(size),
                         .mode_i(mode), .res_o(res), .illegal_o(illegal));

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic s,
                                        int sz, int md);
    logic [63:0] r = 0;
    int n = 8 << sz;
    longint mask = (longint'(1) << n) - 1;
    if (sz == 3 || md == 3 || (md != 0 && sz == 2)) return 64'd0;
    for (int i = 0; i < 64 / n; i++) begin
      longint ua = longint'((a >> (i * n))) & mask;
      longint ub = longint'((b >> (i * n))) & mask;
      longint sa = (ua >= (longint'(1) << (n - 1))) ? ua - (longint'(1) << n) : ua;
      longint sb = (ub >= (longint'(1) << (n - 1))) ? ub - (longint'(1) << n) : ub;
      longint v;
      if (md == 1) begin
        v = s ? sa - sb : sa + sb;
        if (v > (longint'(1) << (n - 1)) - 1) v = (longint'(1) << (n - 1)) - 1;
        if (v < -(longint'(1) << (n - 1))) v = -(longint'(1) << (n - 1));
      end else begin
        v = s ? ua - ub : ua + ub;
        if (md == 2 && v < 0) v = 0;
        if (md == 2 && v > mask) v = mask;
      end
      r = r | ((64'(v) & 64'(mask)) << (i * n));
    end
    return r;
  endfunction

  function automatic logic [63:0] fill(int sz, int idx);
    int n = 8 << sz;
    longint h = longint'(1) << (n - 1);
    longint vals [7] = '{0, 1, h - 1, h, 2 * h - 1, h + 1, h - 2};
    logic [63:0] r = 0;
    for (int i = 0; i < 64 / n; i++) r = r | (64'(vals[idx]) << (i * n));
    return r;
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, logic s, int sz, int md);
    logic [63:0] exp;
    logic expi;
    string tag;
    @(negedge clk);
    dst = a; src = b; sub = s; size = 2'(sz); mode = 2'(md);
    @(posedge clk); #1;
    exp = model(a, b, s, sz, md);
    expi = (sz == 3 || md == 3 || (md != 0 && sz == 2));
    if (expi) tag = (sz == 2 && md != 3) ? "R7" : "R8";
    else if (md == 0) tag = s ? "R1/R5" : "R1";
    else if (md == 1) tag = s ? "R2/R5" : "R2";
    else tag = s ? "R4/R5" : "R3";
    checks++;
    if (illegal !== expi) begin
      failures++;
      $display("FAIL %s illegal sz=%0d md=%0d got=%b exp=%b", tag, sz, md, illegal, expi);
    end
    checks++;
    if (res !== exp) begin
      failures++;
      $display("FAIL %s res sz=%0d md=%0d sub=%0b a=%h b=%h got=%h exp=%h",
               tag, sz, md, s, a, b, res, exp);
    end
  endtask

  initial begin
    dst = 0; src = 0; sub = 0; size = 0; mode = 0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    // Initial state: zero operands give zero result, legal
    apply(64'd0, 64'd0, 0, 0, 0);
    // R6: carries and borrows stay inside lanes
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0);
    apply(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 1, 1, 0);
    apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 0, 1, 0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2, 0);
    for (int sz = 0; sz < 4; sz++)
      for (int md = 0; md < 4; md++)
        for (int s = 0; s < 2; s++) begin
          for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
              apply(fill(sz, i), fill(sz, j), 1'(s), sz, md);
          for (int r = 0; r < 16; r++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, 1'(s), sz, md);
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule